// File: doc/BRIEF.md
# Interrupt Cause and Mask Unit

This block gathers one-cycle event pulses from the transmit, receive, link, management and general-purpose logic of a network controller. Each pulse sets a sticky bit in a cause register. An enable mask chooses which causes may raise the single level-sensitive interrupt line. Software reaches the block over a plain 32-bit register bus. A read of the cause register returns the pending causes and clears them. A separate register lets software inject causes to test its handler. The mask has two write ports: one turns enable bits on and the other turns them off. Because of this split, software never needs a read-modify-write sequence.

Each bus access takes one cycle. A write takes effect at the clock edge where it is presented. Read data is registered and appears on `bus_rdata` in the cycle after the read strobe. In all other cycles `bus_rdata` is zero. The interrupt output is also registered. It reflects the cause and mask values that the same edge produces.

Top module: `irq_cause_unit`

## Requirements
- R1: After reset, the cause and mask registers are zero, `irq_o` is low, and a read of either register returns zero.
- R2: A one-cycle pulse on `evt_i[b]` sets cause bit b, and the bit stays set until it is cleared. The implemented cause positions are: 0 transmit descriptor done, 1 transmit queue empty, 2 link change, 3 receive sequence error, 4 receive descriptor low threshold, 6 receive overrun, 7 receive timer, 9 management access done, 10 configuration sets seen, and 11 to 14 general-purpose inputs. All implemented bits together give 0x00007EDF.
- R3: A read at byte offset 0xC0 returns the cause value on `bus_rdata` one cycle later and clears the cause register at the same edge.
- R4: An event that arrives in the same cycle as a cause read is not returned by that read. It stays pending for the next read.
- R5: A write at offset 0xC8 ORs the written value into the cause register, exactly as if those events had fired.
- R6: A write at offset 0xD0 ORs the written value into the mask. A read at 0xD0 returns the current mask one cycle later.
- R7: A write at offset 0xD8 clears every mask bit that is written as one and leaves all other mask bits unchanged. Writing all ones clears the whole mask.
- R8: After every clock edge, `irq_o` is high exactly when the bitwise AND of the cause and mask values set at that edge is non-zero.
- R9: Bits 5, 8 and 15 to 31 are reserved. They read as zero in both registers. Events, cause-set writes and mask-set writes cannot set them.
- R10: Reads at 0xC8, 0xD8 or any unmapped offset return zero. Writes at unmapped offsets change neither register. `bus_rdata` is zero in every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (16) | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| evt_i | input | 32 | One-cycle event pulses, one per cause position |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench first fires each implemented event on its own and then fires all 32 event lines at once. Comparing the two runs separates correct bit positions from reserved-bit leakage. It places an event in the same cycle as a cause read, which shows whether the read-clear swallows a simultaneous event. The mask is built up through set writes and torn down through clear writes, with unmasked causes present the whole time. This shows whether the interrupt follows the AND of cause and mask or follows either register alone. Writes and reads at neighbouring and unmapped offsets confirm that the address decode is exact.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  localparam int REG_W = 32;

  // Cause bit positions (fixed encoding decoded by software)
  localparam int CB_TX_DONE   = 0;
  localparam int CB_TX_EMPTY  = 1;
  localparam int CB_LINK_CHG  = 2;
  localparam int CB_RX_SEQERR = 3;
  localparam int CB_RX_LOWDSC = 4;
  localparam int CB_RX_OVRRUN = 6;
  localparam int CB_RX_TIMER  = 7;
  localparam int CB_MGMT_DONE = 9;
  localparam int CB_CFG_SEEN  = 10;
  localparam int CB_GP_BASE   = 11;
  localparam int CB_GP_COUNT  = 4;

  // Register byte offsets
  localparam int OFS_CAUSE_RD  = 'hC0;
  localparam int OFS_CAUSE_SET = 'hC8;
  localparam int OFS_MASK_SET  = 'hD0;
  localparam int OFS_MASK_CLR  = 'hD8;

  function automatic logic [REG_W-1:0] impl_bits();
    logic [REG_W-1:0] m;
    m = '0;
    m[CB_TX_DONE]   = 1'b1;
    m[CB_TX_EMPTY]  = 1'b1;
    m[CB_LINK_CHG]  = 1'b1;
    m[CB_RX_SEQERR] = 1'b1;
    m[CB_RX_LOWDSC] = 1'b1;
    m[CB_RX_OVRRUN] = 1'b1;
    m[CB_RX_TIMER]  = 1'b1;
    m[CB_MGMT_DONE] = 1'b1;
    m[CB_CFG_SEEN]  = 1'b1;
    for (int g = 0; g < CB_GP_COUNT; g++) m[CB_GP_BASE+g] = 1'b1;
    return m;
  endfunction

  localparam logic [REG_W-1:0] IMPL_MASK = impl_bits();

  typedef struct packed {
    logic cause_rd;
    logic cause_set;
    logic mask_set;
    logic mask_clr;
    logic mask_rd;
  } reg_sel_t;

endpackage

// File: rtl/irq_decode.sv
module irq_decode
  import irq_ctrl_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output reg_sel_t          sel
);

  logic hit_cause, hit_cset, hit_mset, hit_mclr;

  always_comb begin
    hit_cause = (bus_addr == ADDR_W'(OFS_CAUSE_RD));
    hit_cset  = (bus_addr == ADDR_W'(OFS_CAUSE_SET));
    hit_mset  = (bus_addr == ADDR_W'(OFS_MASK_SET));
    hit_mclr  = (bus_addr == ADDR_W'(OFS_MASK_CLR));
    sel.cause_rd  = bus_rd & hit_cause;
    sel.cause_set = bus_wr & hit_cset;
    sel.mask_set  = bus_wr & hit_mset;
    sel.mask_clr  = bus_wr & hit_mclr;
    sel.mask_rd   = bus_rd & hit_mset;
  end

  // R10: at most one mask write strobe per cycle
  assert_one_mask_write_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel.mask_set, sel.mask_clr, sel.cause_set}))
    else $error("decode produced two write strobes");

endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
  parameter int             W    = 32,
  parameter logic [W-1:0]   IMPL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_i,
  input  logic         set_we,
  input  logic [W-1:0] set_data,
  input  logic         rd_clr,
  output logic [W-1:0] cause_q,
  output logic [W-1:0] cause_nxt
);

  logic [W-1:0] arrive;
  logic [W-1:0] kept;

  always_comb begin
    arrive    = (evt_i | ({W{set_we}} & set_data)) & IMPL;
    kept      = rd_clr ? '0 : cause_q;
    cause_nxt = kept | arrive;
  end

  always_ff @(posedge clk) begin
    if (rst) cause_q <= '0;
    else     cause_q <= cause_nxt;
  end

  // R9: reserved positions never hold a one
  assert_reserved_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (cause_q & ~IMPL) == '0)
    else $error("reserved cause bit set");

  // R4: an implemented event is always captured at the next edge
  assert_event_kept_R4: assert property (@(posedge clk) disable iff (rst)
    (|(evt_i & IMPL)) |=> ((cause_q & $past(evt_i & IMPL)) == $past(evt_i & IMPL)))
    else $error("event lost");

  // R3: a read with nothing arriving leaves the register empty
  assert_read_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && !set_we && ((evt_i & IMPL) == '0)) |=> (cause_q == '0))
    else $error("cause not cleared by read");

  // R2: with no read, no bit falls
  assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_clr |=> ((cause_q & $past(cause_q)) == $past(cause_q)))
    else $error("cause bit dropped without read");

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int           W    = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] mask_nxt
);

  always_comb begin
    mask_nxt = mask_q;
    if (set_we) mask_nxt = mask_q | (wdata & IMPL);
    if (clr_we) mask_nxt = mask_q & ~wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_nxt;
  end

  // R6: set write turns on every implemented written bit
  assert_mask_set_R6: assert property (@(posedge clk) disable iff (rst)
    set_we |=> ((mask_q & $past(wdata & IMPL)) == $past(wdata & IMPL)))
    else $error("mask set failed");

  // R7: clear write turns off every written bit
  assert_mask_clear_R7: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((mask_q & $past(wdata)) == '0))
    else $error("mask clear failed");

  // R7: without writes the mask holds
  assert_mask_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!set_we && !clr_we) |=> $stable(mask_q))
    else $error("mask changed without write");

  // R9: reserved mask bits stay zero
  assert_mask_reserved_R9: assert property (@(posedge clk) disable iff (rst)
    (mask_q & ~IMPL) == '0)
    else $error("reserved mask bit set");

endmodule

// File: rtl/irq_cause_unit.sv
module irq_cause_unit
  import irq_ctrl_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [REG_W-1:0]  evt_i,
  output logic              irq_o
);

  reg_sel_t         sel;
  logic [REG_W-1:0] cause_q, cause_nxt;
  logic [REG_W-1:0] mask_q, mask_nxt;
  logic [REG_W-1:0] rd_mux;

  irq_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .sel      (sel)
  );

  irq_cause_reg #(.W(REG_W), .IMPL(IMPL_MASK)) u_cause (
    .clk       (clk),
    .rst       (rst),
    .evt_i     (evt_i),
    .set_we    (sel.cause_set),
    .set_data  (bus_wdata),
    .rd_clr    (sel.cause_rd),
    .cause_q   (cause_q),
    .cause_nxt (cause_nxt)
  );

  irq_mask_reg #(.W(REG_W), .IMPL(IMPL_MASK)) u_mask (
    .clk      (clk),
    .rst      (rst),
    .set_we   (sel.mask_set),
    .clr_we   (sel.mask_clr),
    .wdata    (bus_wdata),
    .mask_q   (mask_q),
    .mask_nxt (mask_nxt)
  );

  always_comb begin
    rd_mux = '0;
    if (sel.cause_rd)     rd_mux = cause_q;
    else if (sel.mask_rd) rd_mux = mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_o     <= 1'b0;
    end else begin
      bus_rdata <= rd_mux;
      irq_o     <= |(cause_nxt & mask_nxt);
    end
  end

  // R8: the interrupt line tracks cause AND mask as registered by the two register modules
  assert_irq_level_R8: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|(cause_q & mask_q)))
    else $error("irq level mismatch");

  // R10: no read, or a read of a non-readable offset, yields zero data
  assert_rdata_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (!sel.cause_rd && !sel.mask_rd) |=> (bus_rdata == '0))
    else $error("rdata not zero");

endmodule

// File: tb/irq_cause_unit_tb.sv
module irq_cause_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] evt = '0;
  logic        irq_o;

  int n_checks = 0;
  int n_errors = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  localparam logic [31:0] ALL_IMPL = 32'h0000_7EDF;

  always #5 clk = ~clk;

  irq_cause_unit u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt), .irq_o(irq_o)
  );

  always @(posedge clk) rd_seen <= bus_rd;

  // Monitor: compare registered read data with scoreboard entries
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if (bus_rdata !== e) begin
        n_errors++;
        $display("FAIL %s read data: actual=%h expected=%h", t, bus_rdata, e);
      end
    end else if (!rd_seen && !rst) begin
      if (bus_rdata !== 32'h0) begin
        n_checks++;
        n_errors++;
        $display("FAIL R10 idle read data: actual=%h expected=%h", bus_rdata, 32'h0);
      end
    end
  end

  task automatic bus_read(input logic [15:0] a, input logic [31:0] e,
                          input string t, input logic [31:0] ev);
    bus_addr = a; bus_rd = 1'b1; evt = ev;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0; evt = '0;
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic pulse(input logic [31:0] ev);
    evt = ev;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic check_irq(input logic e, input string t);
    n_checks++;
    if (irq_o !== e) begin
      n_errors++;
      $display("FAIL %s irq: actual=%b expected=%b", t, irq_o, e);
    end
  endtask

  initial begin
    #(200000 * 10);
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check_irq(1'b0, "R1");
    bus_read(16'h00C0, 32'h0, "R1", 32'h0);
    bus_read(16'h00D0, 32'h0, "R1", 32'h0);

    // R2 each implemented event alone
    for (int b = 0; b < 32; b++) if (ALL_IMPL[b]) pulse(32'h1 << b);
    bus_read(16'h00C0, ALL_IMPL, "R2", 32'h0);
    // R3 read cleared it
    bus_read(16'h00C0, 32'h0, "R3", 32'h0);

    // R9 all lines at once
    pulse(32'hFFFF_FFFF);
    bus_read(16'h00C0, ALL_IMPL, "R9", 32'h0);
    bus_read(16'h00C0, 32'h0, "R3", 32'h0);

    // R4 event together with a read
    pulse(32'h1);
    bus_read(16'h00C0, 32'h1, "R4", 32'h4);
    bus_read(16'h00C0, 32'h4, "R4", 32'h0);

    // R5 software cause set
    bus_write(16'h00C8, 32'hFFFF_FFFF);
    bus_read(16'h00C0, ALL_IMPL, "R5", 32'h0);
    bus_write(16'h00C8, 32'h0000_0200);
    bus_read(16'h00C0, 32'h0000_0200, "R5", 32'h0);

    // R6 mask set accumulates, reserved bits dropped
    bus_write(16'h00D0, 32'h0000_0005);
    bus_write(16'h00D0, 32'h8000_0180);
    bus_read(16'h00D0, 32'h0000_0085, "R6", 32'h0);

    // R8 irq follows cause AND mask
    check_irq(1'b0, "R8");
    pulse(32'h2);
    check_irq(1'b0, "R8");
    pulse(32'h80);
    check_irq(1'b1, "R8");

    // R7 mask clear
    bus_write(16'h00D8, 32'h0000_0080);
    check_irq(1'b0, "R7");
    bus_read(16'h00D0, 32'h0000_0005, "R7", 32'h0);
    bus_write(16'h00D0, 32'h0000_0002);
    check_irq(1'b1, "R8");
    bus_read(16'h00C0, 32'h0000_0082, "R3", 32'h0);
    check_irq(1'b0, "R8");
    bus_write(16'h00D8, 32'hFFFF_FFFF);
    bus_read(16'h00D0, 32'h0, "R7", 32'h0);

    // R10 decode exactness
    bus_write(16'h00C8, 32'h0000_0008);
    bus_write(16'h0000, 32'hFFFF_FFFF);
    bus_write(16'h00C4, 32'hFFFF_FFFF);
    bus_write(16'h00D4, 32'hFFFF_FFFF);
    bus_write(16'h01D0, 32'hFFFF_FFFF);
    bus_read(16'h00C8, 32'h0, "R10", 32'h0);
    bus_read(16'h00D8, 32'h0, "R10", 32'h0);
    bus_read(16'h0000, 32'h0, "R10", 32'h0);
    bus_read(16'h00D0, 32'h0, "R10", 32'h0);
    bus_read(16'h00C0, 32'h0000_0008, "R10", 32'h0);
    check_irq(1'b0, "R10");

    repeat (3) @(negedge clk);
    n_checks++;
    if (exp_q.size() != 0) begin
      n_errors++;
      $display("FAIL scoreboard drain: actual=%0d expected=0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule